// File: doc/BRIEF.md
# Platform Control and Status Register File

This block is a small 32-bit register file that sits on a simple request bus and reports how the platform was built and what state it is in. It composes read values for build identity, clock generator setup, external memory status and size, and the enable and lock state of the serial interconnect links. Most values come from elaboration parameters: the reference clock in MHz, the memory size in GiB, the link enable mask and a coherence-unit flag. The lock state of each link comes from live status inputs.

Software reaches it with single-beat requests. Each request carries a valid strobe, a write flag, an address, a size code and write data. Only word accesses are served, and the register offset is taken from the low sixteen address bits. Read data, the unimplemented-access flag and the system-reset request all come out registered, one cycle after the request. The only writable function is a request for a whole-system reset. Every other known register ignores writes.

Top module: `plat_ctrl_regs`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, rdata_o, sys_rst_req_o and unimpl_o are all zero.
- R2: A request whose req_size_i is not 2'b10 (size codes: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = 8 bytes) returns zero read data and changes nothing. It pulses unimpl_o one cycle later.
- R3: The register offset is req_addr_i[15:0]. Address bits 31:16 do not affect the result.
- R4: Word reads of offsets 0x00, 0x04, 0x08 (build identity words) and 0x10 (reset control) return zero and do not raise unimpl_o.
- R5: A word read of offset 0x14 (memory status) returns 0x0000_0005: bit 0 is locked and bit 2 is calibrated.
- R6: A word read of offset 0x18 (link status) returns link_locked_i[k] at bit 8*k for each link. All other bits are zero. The inputs are sampled in the request cycle.
- R7: A word read of offset 0x30 (clock setup) returns divide-0 = 1 in bits 7:0, REF_MHZ in bits 15:8, multiply = 1 in bits 23:16 and divide-1 = 1 in bits 31:24. With the defaults this is 0x0101_6401.
- R8: A word read of offset 0x34 (build options) returns COHERENT_EN in bit 0 and LINK_EN[k] in bit k+1. All other bits are zero. With the defaults this is 0x0000_000E.
- R9: A word read of offset 0x38 (memory setup) returns MEM_GIB in bits 3:0 and all ones in bits 15:4. All other bits are zero. With the defaults this is 0x0000_FFF1.
- R10: A word write to offset 0x10 with bit 4 set drives sys_rst_req_o high for the one following cycle. The same write with bit 4 clear, or with any other size, leaves it low.
- R11: Word writes to offsets 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34 and 0x38 have no effect. Later reads return the same values, and unimpl_o stays low.
- R12: A word access to any other offset, including a misaligned one, reads as zero and raises unimpl_o for the one following cycle. This holds for both reads and writes.
- R13: The read response appears on rdata_o in the cycle after the request. rdata_o is zero in every cycle that does not follow an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one beat per cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address; only bits 15:0 are decoded |
| req_size_i | input | 2 | Access size code; 2'b10 = 4 bytes |
| req_wdata_i | input | 32 | Write data |
| link_locked_i | input | NUM_LINKS | Per-link lock status |
| rdata_o | output | 32 | Registered read data |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| unimpl_o | output | 1 | One-cycle flag for a bad size or an unknown offset |

## Verification
On every cycle, the assertions check four things. Any read data or flag must trace back to the request of the previous cycle. A reset request must come only from a qualifying word write to the reset control offset. Wrong-size accesses must always read zero and flag. A reset pulse and an unimplemented flag must never appear together. The exact packing of each status word under live link inputs can only be shown by the bench's scenarios. So can the way upper address bits are ignored, and the read-back after writes to read-only offsets. The bench mixes random traffic with directed sequences for each of these.

// File: rtl/plat_ctrl_pkg.sv
package plat_ctrl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFF_W    = 16;
  localparam logic [1:0]  SZ_WORD  = 2'b10;
  localparam int unsigned RST_BIT  = 4;
  localparam int unsigned MAX_LNK  = 4;

  localparam logic [OFF_W-1:0] OFF_ID0    = 16'h0000;
  localparam logic [OFF_W-1:0] OFF_ID1    = 16'h0004;
  localparam logic [OFF_W-1:0] OFF_ID2    = 16'h0008;
  localparam logic [OFF_W-1:0] OFF_RSTCTL = 16'h0010;
  localparam logic [OFF_W-1:0] OFF_MEMST  = 16'h0014;
  localparam logic [OFF_W-1:0] OFF_LNKST  = 16'h0018;
  localparam logic [OFF_W-1:0] OFF_CLKSET = 16'h0030;
  localparam logic [OFF_W-1:0] OFF_BLDOPT = 16'h0034;
  localparam logic [OFF_W-1:0] OFF_MEMSET = 16'h0038;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ZERO,
    SEL_RSTCTL,
    SEL_MEMST,
    SEL_LNKST,
    SEL_CLKSET,
    SEL_BLDOPT,
    SEL_MEMSET
  } reg_sel_e;
endpackage

// File: rtl/plat_addr_dec.sv
module plat_addr_dec
  import plat_ctrl_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  output reg_sel_e         sel_o
);
  always_comb begin
    unique case (off_i)
      OFF_ID0, OFF_ID1, OFF_ID2: sel_o = SEL_ZERO;
      OFF_RSTCTL:                sel_o = SEL_RSTCTL;
      OFF_MEMST:                 sel_o = SEL_MEMST;
      OFF_LNKST:                 sel_o = SEL_LNKST;
      OFF_CLKSET:                sel_o = SEL_CLKSET;
      OFF_BLDOPT:                sel_o = SEL_BLDOPT;
      OFF_MEMSET:                sel_o = SEL_MEMSET;
      default:                   sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/plat_rd_mux.sv
module plat_rd_mux
  import plat_ctrl_pkg::*;
#(
  parameter int unsigned          NUM_LINKS   = 3,
  parameter logic [7:0]           REF_MHZ     = 8'd100,
  parameter logic [3:0]           MEM_GIB     = 4'd1,
  parameter logic [NUM_LINKS-1:0] LINK_EN     = '1,
  parameter logic                 COHERENT_EN = 1'b0
) (
  input  reg_sel_e              sel_i,
  input  logic [NUM_LINKS-1:0]  link_locked_i,
  output logic [DATA_W-1:0]     data_o
);
  localparam logic [DATA_W-1:0] MEMST_VAL  = 32'h0000_0005;
  localparam logic [DATA_W-1:0] CLKSET_VAL = {8'd1, 8'd1, REF_MHZ, 8'd1};
  localparam logic [DATA_W-1:0] BLDOPT_VAL = DATA_W'({LINK_EN, COHERENT_EN});
  localparam logic [DATA_W-1:0] MEMSET_VAL = {16'h0000, 12'hfff, MEM_GIB};

  // one byte lane per link, lock flag in the lane's lsb
  logic [MAX_LNK-1:0][7:0] lnk_lane;

  for (genvar k = 0; k < MAX_LNK; k++) begin : g_lane
    if (k < NUM_LINKS) begin : g_used
      assign lnk_lane[k] = {7'b0, link_locked_i[k]};
    end else begin : g_unused
      assign lnk_lane[k] = 8'h00;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_MEMST:  data_o = MEMST_VAL;
      SEL_LNKST:  data_o = lnk_lane;
      SEL_CLKSET: data_o = CLKSET_VAL;
      SEL_BLDOPT: data_o = BLDOPT_VAL;
      SEL_MEMSET: data_o = MEMSET_VAL;
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/plat_rst_pulse.sv
module plat_rst_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= fire_i;
  end
endmodule

// File: rtl/plat_ctrl_regs.sv
module plat_ctrl_regs
  import plat_ctrl_pkg::*;
#(
  parameter int unsigned          NUM_LINKS   = 3,
  parameter logic [7:0]           REF_MHZ     = 8'd100,
  parameter logic [3:0]           MEM_GIB     = 4'd1,
  parameter logic [NUM_LINKS-1:0] LINK_EN     = '1,
  parameter logic                 COHERENT_EN = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [31:0]          req_addr_i,
  input  logic [1:0]           req_size_i,
  input  logic [31:0]          req_wdata_i,
  input  logic [NUM_LINKS-1:0] link_locked_i,
  output logic [31:0]          rdata_o,
  output logic                 sys_rst_req_o,
  output logic                 unimpl_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] mux_data;
  logic              size_ok, known, rd_hit, rst_fire, unimpl_d;

  plat_addr_dec u_dec (
    .off_i (req_addr_i[OFF_W-1:0]),
    .sel_o (sel)
  );

  plat_rd_mux #(
    .NUM_LINKS   (NUM_LINKS),
    .REF_MHZ     (REF_MHZ),
    .MEM_GIB     (MEM_GIB),
    .LINK_EN     (LINK_EN),
    .COHERENT_EN (COHERENT_EN)
  ) u_mux (
    .sel_i         (sel),
    .link_locked_i (link_locked_i),
    .data_o        (mux_data)
  );

  assign size_ok  = (req_size_i == SZ_WORD);
  assign known    = (sel != SEL_NONE);
  assign rd_hit   = req_valid_i && !req_write_i && size_ok;
  assign unimpl_d = req_valid_i && (!size_ok || !known);
  assign rst_fire = req_valid_i && req_write_i && size_ok &&
                    (sel == SEL_RSTCTL) && req_wdata_i[RST_BIT];

  plat_rst_pulse u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (rst_fire),
    .pulse_o (sys_rst_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      unimpl_o <= 1'b0;
    end else begin
      rdata_o  <= rd_hit ? mux_data : '0;
      unimpl_o <= unimpl_d;
    end
  end
endmodule

// File: rtl/plat_ctrl_regs_chk.sv
module plat_ctrl_regs_chk #(
  parameter int unsigned NUM_LINKS = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_write_i,
  input logic [31:0]          req_addr_i,
  input logic [1:0]           req_size_i,
  input logic [31:0]          req_wdata_i,
  input logic [NUM_LINKS-1:0] link_locked_i,
  input logic [31:0]          rdata_o,
  input logic                 sys_rst_req_o,
  input logic                 unimpl_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R13
  rdata_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(req_valid_i && !req_write_i)) |-> (rdata_o == 32'h0));

  // R10
  rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && sys_rst_req_o) |->
      $past(req_valid_i && req_write_i && req_size_i == 2'b10 &&
            req_addr_i[15:0] == 16'h0010 && req_wdata_i[4]));

  // R2
  bad_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(req_valid_i && req_size_i != 2'b10)) |->
      (rdata_o == 32'h0 && unimpl_o && !sys_rst_req_o));

  // R12
  unimpl_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && unimpl_o) |-> $past(req_valid_i));

  // R12
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(unimpl_o && sys_rst_req_o));

  // R5
  memst_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(req_valid_i && !req_write_i && req_size_i == 2'b10 &&
                      req_addr_i[15:0] == 16'h0014)) |-> (rdata_o == 32'h5));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (rdata_o == 32'h0 && !sys_rst_req_o && !unimpl_o);
    end
  end
endmodule

bind plat_ctrl_regs plat_ctrl_regs_chk #(.NUM_LINKS(NUM_LINKS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_write_i   (req_write_i),
  .req_addr_i    (req_addr_i),
  .req_size_i    (req_size_i),
  .req_wdata_i   (req_wdata_i),
  .link_locked_i (link_locked_i),
  .rdata_o       (rdata_o),
  .sys_rst_req_o (sys_rst_req_o),
  .unimpl_o      (unimpl_o)
);

// File: tb/plat_ctrl_regs_tb_top.sv
module plat_ctrl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_write_i = 1'b0;
  logic [31:0]   req_addr_i = '0;
  logic [1:0]    req_size_i = 2'b10;
  logic [31:0]   req_wdata_i = '0;
  logic [NL-1:0] link_locked_i = '0;
  logic [31:0]   rdata_o;
  logic          sys_rst_req_o;
  logic          unimpl_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  plat_ctrl_regs dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .req_addr_i    (req_addr_i),
    .req_size_i    (req_size_i),
    .req_wdata_i   (req_wdata_i),
    .link_locked_i (link_locked_i),
    .rdata_o       (rdata_o),
    .sys_rst_req_o (sys_rst_req_o),
    .unimpl_o      (unimpl_o)
  );

  function automatic bit is_known(logic [15:0] off);
    return off inside {16'h00, 16'h04, 16'h08, 16'h10, 16'h14,
                       16'h18, 16'h30, 16'h34, 16'h38};
  endfunction

  function automatic logic [31:0] exp_rd(logic v, logic w, logic [31:0] a,
                                         logic [1:0] sz, logic [NL-1:0] lk);
    logic [31:0] r;
    r = '0;
    if (v && !w && sz == 2'b10) begin
      case (a[15:0])
        16'h14: r = 32'h0000_0005;
        16'h18: r = {15'b0, lk[2], 7'b0, lk[1], 7'b0, lk[0]};
        16'h30: r = 32'h0101_6401;
        16'h34: r = 32'h0000_000e;
        16'h38: r = 32'h0000_fff1;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(logic w, logic [31:0] a, logic [1:0] sz);
    if (sz != 2'b10) return "R2";
    if (!is_known(a[15:0])) return "R12";
    if (w) return (a[15:0] == 16'h10) ? "R10" : "R11";
    case (a[15:0])
      16'h14: return "R5";
      16'h18: return "R6";
      16'h30: return "R7";
      16'h34: return "R8";
      16'h38: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // drive one request (or idle when v=0) and check the registered response
  task automatic xact(logic v, logic w, logic [31:0] a, logic [1:0] sz,
                      logic [31:0] d, logic [NL-1:0] lk, string req);
    logic er, eu;
    @(negedge clk_i);
    req_valid_i = v; req_write_i = w; req_addr_i = a;
    req_size_i = sz; req_wdata_i = d; link_locked_i = lk;
    er = v && w && sz == 2'b10 && a[15:0] == 16'h10 && d[4];
    eu = v && (sz != 2'b10 || !is_known(a[15:0]));
    @(posedge clk_i);
    #1;
    check(req, rdata_o, exp_rd(v, w, a, sz, lk));
    check(req, {31'b0, sys_rst_req_o}, {31'b0, er});
    check(req, {31'b0, unimpl_o}, {31'b0, eu});
  endtask

  task automatic idle(string req);
    xact(1'b0, 1'b0, 32'h0, 2'b10, 32'h0, link_locked_i, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: outputs quiet in reset, even with a request present
    req_valid_i = 1'b1; req_addr_i = 32'h14;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", rdata_o, 32'h0);
    check("R1", {31'b0, sys_rst_req_o}, 32'h0);
    check("R1", {31'b0, unimpl_o}, 32'h0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    rst_ni = 1'b1;
    idle("R1");

    // R4 / R5 / R7 / R8 / R9 directed reads
    xact(1, 0, 32'h0000_0000, 2'b10, 0, 3'b000, "R4");
    xact(1, 0, 32'h0000_0004, 2'b10, 0, 3'b000, "R4");
    xact(1, 0, 32'h0000_0008, 2'b10, 0, 3'b000, "R4");
    xact(1, 0, 32'h0000_0010, 2'b10, 0, 3'b000, "R4");
    xact(1, 0, 32'h0000_0014, 2'b10, 0, 3'b000, "R5");
    xact(1, 0, 32'h0000_0030, 2'b10, 0, 3'b000, "R7");
    xact(1, 0, 32'h0000_0034, 2'b10, 0, 3'b000, "R8");
    xact(1, 0, 32'h0000_0038, 2'b10, 0, 3'b000, "R9");
    // R6 each link lane alone and together
    xact(1, 0, 32'h18, 2'b10, 0, 3'b001, "R6");
    xact(1, 0, 32'h18, 2'b10, 0, 3'b010, "R6");
    xact(1, 0, 32'h18, 2'b10, 0, 3'b100, "R6");
    xact(1, 0, 32'h18, 2'b10, 0, 3'b111, "R6");
    // R3 upper address bits ignored
    xact(1, 0, 32'habcd_0014, 2'b10, 0, 3'b000, "R3");
    xact(1, 0, 32'hffff_0038, 2'b10, 0, 3'b000, "R3");
    xact(1, 0, 32'h0001_0050, 2'b10, 0, 3'b000, "R3");
    // R2 every non-word size, read and write
    xact(1, 0, 32'h14, 2'b00, 0, 3'b000, "R2");
    xact(1, 0, 32'h30, 2'b01, 0, 3'b000, "R2");
    xact(1, 0, 32'h38, 2'b11, 0, 3'b000, "R2");
    xact(1, 1, 32'h10, 2'b00, 32'hffff_ffff, 3'b000, "R2");
    xact(1, 1, 32'h10, 2'b11, 32'h10, 3'b000, "R2");
    // R10 reset request pulse, one cycle only
    xact(1, 1, 32'h10, 2'b10, 32'h0000_0010, 3'b000, "R10");
    idle("R10");
    xact(1, 1, 32'h10, 2'b10, 32'hffff_ffef, 3'b000, "R10");
    xact(1, 1, 32'h7777_0010, 2'b10, 32'h0000_0010, 3'b000, "R10");
    idle("R10");
    // R11 writes to read-only offsets then read back
    xact(1, 1, 32'h38, 2'b10, 32'hffff_ffff, 3'b000, "R11");
    xact(1, 1, 32'h30, 2'b10, 32'h0, 3'b000, "R11");
    xact(1, 1, 32'h14, 2'b10, 32'h0, 3'b000, "R11");
    xact(1, 1, 32'h00, 2'b10, 32'h1234_5678, 3'b000, "R11");
    xact(1, 0, 32'h38, 2'b10, 0, 3'b000, "R11");
    xact(1, 0, 32'h30, 2'b10, 0, 3'b000, "R11");
    xact(1, 0, 32'h14, 2'b10, 0, 3'b000, "R11");
    xact(1, 0, 32'h00, 2'b10, 0, 3'b000, "R11");
    // R12 unknown and misaligned offsets
    xact(1, 0, 32'h1c, 2'b10, 0, 3'b000, "R12");
    xact(1, 0, 32'h15, 2'b10, 0, 3'b000, "R12");
    xact(1, 1, 32'h48, 2'b10, 32'h10, 3'b000, "R12");
    idle("R12");
    // R13 read response followed by idle returns to zero
    xact(1, 0, 32'h34, 2'b10, 0, 3'b000, "R13");
    idle("R13");
    xact(1, 1, 32'h34, 2'b10, 0, 3'b000, "R13");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic        v, w;
      logic [31:0] a, d;
      logic [1:0]  sz;
      logic [NL-1:0] lk;
      v  = ($urandom % 8) != 0;
      w  = $urandom % 2;
      a  = {$urandom % 4 == 0 ? 16'($urandom) : 16'h0,
            16'(($urandom % 20) * 4 + (($urandom % 10 == 0) ? 1 : 0))};
      sz = ($urandom % 4 == 0) ? 2'($urandom) : 2'b10;
      d  = $urandom;
      if ($urandom % 4 == 0) d[4] = 1'b1;
      lk = NL'($urandom);
      if (v) xact(v, w, a, sz, d, lk, tag_of(w, a, sz));
      else   xact(v, w, a, sz, d, lk, "R13");
    end
    idle("R13");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule